// File: doc/BRIEF.md
# DLL Lock and Impedance Readiness Sequencer

This control block decides when a synchronous memory device may take commands and when its output driver impedance can be trusted. An enable input stands in for the delay-locked loop's disable pin. While the enable is high, a counter models the loop's lock delay. The device is reported locked, and commands are allowed, only once that wait has finished.

Three events restart the lock wait:
- a clock-loss indication, which may be a one-cycle pulse or a level;
- a request to change the operating frequency;
- the enable going low.

A restart requested while memory operations are still outstanding is held back. The block stays locked but stops accepting commands until those operations drain.

A second, independent path tracks output impedance calibration. It counts cycles without a read since reset and raises a calibrated flag once enough quiet cycles have gone by. It also issues a periodic one-cycle update strobe. That strobe is released only in a cycle where no read is issued and the outputs are not driving. An update that falls due during read traffic is deferred until the first idle cycle.

Top module: `dll_ready_seq`

## Requirements
- R1: While `rst` is sampled high, all four outputs (`dll_locked`, `ready`, `zq_upd`, `zq_cal`) are low at the following sample point.
- R2: A rising edge that samples `dll_en` low makes `dll_locked` and `ready` low after that edge, whatever the other inputs are. The next lock wait starts at the first edge that samples `dll_en` high.
- R3: `dll_locked` and `ready` rise after exactly LOCK_CYCLES (default 2048) rising edges. The edge that starts the wait counts as the first of these edges.
- R4: `ready` is high only while locked with no restart pending. When a restart is requested, `ready` drops after the requesting edge.
- R5: An edge that samples `clk_lost` high while locked with `ops_pend` low makes `dll_locked` low after that edge. The block stays unlocked for as long as `clk_lost` remains high. A new lock wait starts at the first edge that samples it low.
- R6: A restart request (`clk_lost` or `freq_chg`) that arrives while `ops_pend` is high keeps `dll_locked` high and holds `ready` low until an edge samples `ops_pend` low. The block remembers which request it received. A remembered clock loss then waits for `clk_lost` to be low before relocking. A remembered frequency change starts the lock wait at that same edge.
- R7: An edge that samples `freq_chg` high while locked or locking with `ops_pend` low restarts the wait. That edge counts as the first of the LOCK_CYCLES edges.
- R8: `zq_cal` rises after SETTLE_CYCLES (default 1024) rising edges since reset that sampled `rd_cmd` low. The edges do not need to be consecutive. Once high, `zq_cal` stays high until reset.
- R9: `zq_upd` is high for a cycle only when the preceding edge sampled both `rd_cmd` and `out_active` low.
- R10: While idle, an update strobe is issued once every UPD_INTERVAL (default 32) cycles. An update that falls due during busy cycles is issued one cycle after the first idle edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dll_en | input | 1 | Lock loop enable; low holds the loop disabled |
| clk_lost | input | 1 | Clock absence detected (pulse or level) |
| freq_chg | input | 1 | Operating frequency change request |
| ops_pend | input | 1 | Read or write operations still outstanding |
| rd_cmd | input | 1 | Read command issued this cycle |
| out_active | input | 1 | Output drivers active this cycle |
| dll_locked | output | 1 | Lock loop counts as locked |
| ready | output | 1 | Commands may be accepted |
| zq_upd | output | 1 | One-cycle impedance update strobe |
| zq_cal | output | 1 | Output impedance settled |

## Verification
A lock counter that is off by one shows up at the ports as `dll_locked` rising one edge early or late. The bench therefore samples both the edge before and the edge at the end of every full-length wait. A wrong remembered restart cause shows up within two edges of `ops_pend` falling: after a drained frequency change the block halts instead of relocking, or after a drained clock loss it relocks too soon, and either way the following lock wait ends at a shifted edge. A faulty update scheduler becomes visible through the exact number of strobes counted over a window of several intervals. It is also visible through the strobe's presence or absence in the first cycle after read traffic or driving outputs stop.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_LOCK  = 3'd1,
    ST_RUN   = 3'd2,
    ST_DRAIN = 3'd3,
    ST_HALT  = 3'd4
  } seq_st_e;
endpackage

// File: rtl/dll_lock_fsm.sv
module dll_lock_fsm
  import dll_seq_pkg::*;
#(
  parameter int LOCK_CYCLES = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic dll_en,
  input  logic clk_lost,
  input  logic freq_chg,
  input  logic ops_pend,
  output logic dll_locked,
  output logic ready
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(LOCK_CYCLES - 2);

  seq_st_e       st;
  logic [CW-1:0] cnt;
  logic          halt_cause;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_OFF;
      cnt        <= '0;
      halt_cause <= 1'b0;
    end else if (!dll_en) begin
      st         <= ST_OFF;
      cnt        <= '0;
      halt_cause <= 1'b0;
    end else begin
      case (st)
        ST_OFF: begin
          st  <= ST_LOCK;
          cnt <= '0;
        end
        ST_LOCK: begin
          if (clk_lost) begin
            st  <= ST_HALT;
            cnt <= '0;
          end else if (freq_chg) begin
            cnt <= '0;
          end else if (cnt == CNT_LAST) begin
            st <= ST_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (clk_lost || freq_chg) begin
            cnt <= '0;
            if (ops_pend) begin
              st         <= ST_DRAIN;
              halt_cause <= clk_lost;
            end else if (clk_lost) begin
              st <= ST_HALT;
            end else begin
              st <= ST_LOCK;
            end
          end
        end
        ST_DRAIN: begin
          cnt        <= '0;
          halt_cause <= halt_cause | clk_lost;
          if (!ops_pend) begin
            st <= (halt_cause || clk_lost) ? ST_HALT : ST_LOCK;
          end
        end
        ST_HALT: begin
          cnt <= '0;
          if (!clk_lost) st <= ST_LOCK;
        end
        default: begin
          st  <= ST_OFF;
          cnt <= '0;
        end
      endcase
    end
  end

  assign dll_locked = (st == ST_RUN) || (st == ST_DRAIN);
  assign ready      = (st == ST_RUN);

  // R2
  en_low_unlocks_chk: assert property (@(posedge clk) disable iff (rst)
    !dll_en |=> (!dll_locked && !ready));

  // R3
  lock_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOCK) |-> (cnt <= CNT_LAST));

  // R4
  restart_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && (clk_lost || freq_chg)) |=> !ready);

  // R6
  drain_keeps_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (dll_en && dll_locked && ops_pend) |=> dll_locked);

  // R5
  halt_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (dll_en && st == ST_HALT && clk_lost) |=> (st == ST_HALT));
endmodule

// File: rtl/zq_cal_sched.sv
module zq_cal_sched #(
  parameter int SETTLE_CYCLES = 1024,
  parameter int UPD_INTERVAL  = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_cmd,
  input  logic out_active,
  output logic zq_upd,
  output logic zq_cal
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam int TW = (UPD_INTERVAL > 2) ? $clog2(UPD_INTERVAL) : 1;
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYCLES);
  localparam logic [TW-1:0] TICK_LAST   = TW'(UPD_INTERVAL - 1);

  logic [SW-1:0] settle_cnt;
  logic [TW-1:0] tick;
  logic          due;
  logic          idle;
  logic          wrap;

  assign idle = !rd_cmd && !out_active;
  assign wrap = (tick == TICK_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      settle_cnt <= '0;
    end else if (!rd_cmd && settle_cnt != SETTLE_LAST) begin
      settle_cnt <= settle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick   <= '0;
      due    <= 1'b0;
      zq_upd <= 1'b0;
    end else begin
      tick   <= wrap ? '0 : tick + 1'b1;
      due    <= (due && !idle) || wrap;
      zq_upd <= due && idle;
    end
  end

  assign zq_cal = (settle_cnt == SETTLE_LAST);

  // R9
  upd_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    zq_upd |-> ($past(!rd_cmd) && $past(!out_active)));

  // R8
  cal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    zq_cal |=> zq_cal);
endmodule

// File: rtl/dll_ready_seq.sv
module dll_ready_seq #(
  parameter int LOCK_CYCLES   = 2048,
  parameter int SETTLE_CYCLES = 1024,
  parameter int UPD_INTERVAL  = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic dll_en,
  input  logic clk_lost,
  input  logic freq_chg,
  input  logic ops_pend,
  input  logic rd_cmd,
  input  logic out_active,
  output logic dll_locked,
  output logic ready,
  output logic zq_upd,
  output logic zq_cal
);
  dll_lock_fsm #(
    .LOCK_CYCLES(LOCK_CYCLES)
  ) u_lock (
    .clk       (clk),
    .rst       (rst),
    .dll_en    (dll_en),
    .clk_lost  (clk_lost),
    .freq_chg  (freq_chg),
    .ops_pend  (ops_pend),
    .dll_locked(dll_locked),
    .ready     (ready)
  );

  zq_cal_sched #(
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .UPD_INTERVAL (UPD_INTERVAL)
  ) u_zq (
    .clk       (clk),
    .rst       (rst),
    .rd_cmd    (rd_cmd),
    .out_active(out_active),
    .zq_upd    (zq_upd),
    .zq_cal    (zq_cal)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!dll_locked && !ready && !zq_upd && !zq_cal));
endmodule

// File: tb/dll_ready_seq_bench.sv
module dll_ready_seq_bench;
  localparam int CLK_P = 10;
  localparam int INTV  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dll_en = 1'b0, clk_lost = 1'b0, freq_chg = 1'b0, ops_pend = 1'b0;
  logic rd_cmd = 1'b0, out_active = 1'b0;
  logic dll_locked, ready, zq_upd, zq_cal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dll_ready_seq #(.LOCK_CYCLES(2048), .SETTLE_CYCLES(1024), .UPD_INTERVAL(INTV)) u_dll_ready_seq (
    .clk(clk), .rst(rst), .dll_en(dll_en), .clk_lost(clk_lost), .freq_chg(freq_chg),
    .ops_pend(ops_pend), .rd_cmd(rd_cmd), .out_active(out_active),
    .dll_locked(dll_locked), .ready(ready), .zq_upd(zq_upd), .zq_cal(zq_cal)
  );

  typedef struct packed {
    logic        en;
    logic        lost;
    logic        fchg;
    logic        pend;
    logic [11:0] n;
    logic        exp_l;
    logic        exp_r;
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 22;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b0,1'b0,1'b0,1'b0,12'd5,   1'b0,1'b0,4'd2}, // R2 disabled
    '{1'b1,1'b0,1'b0,1'b0,12'd2047,1'b0,1'b0,4'd3}, // R3 one short
    '{1'b1,1'b0,1'b0,1'b0,12'd1,   1'b1,1'b1,4'd3}, // R3 locked
    '{1'b1,1'b0,1'b1,1'b0,12'd1,   1'b0,1'b0,4'd7}, // R7 request
    '{1'b1,1'b0,1'b0,1'b0,12'd2046,1'b0,1'b0,4'd7}, // R7 one short
    '{1'b1,1'b0,1'b0,1'b0,12'd1,   1'b1,1'b1,4'd7}, // R7 relocked
    '{1'b1,1'b1,1'b0,1'b1,12'd3,   1'b1,1'b0,4'd6}, // R6 drain on loss
    '{1'b1,1'b0,1'b0,1'b1,12'd3,   1'b1,1'b0,4'd6}, // R6 still draining
    '{1'b1,1'b0,1'b0,1'b0,12'd1,   1'b0,1'b0,4'd6}, // R6 halted
    '{1'b1,1'b0,1'b0,1'b0,12'd1,   1'b0,1'b0,4'd6}, // R6 wait starts
    '{1'b1,1'b0,1'b0,1'b0,12'd2046,1'b0,1'b0,4'd3}, // R3 one short
    '{1'b1,1'b0,1'b0,1'b0,12'd1,   1'b1,1'b1,4'd3}, // R3 locked
    '{1'b1,1'b1,1'b0,1'b0,12'd4,   1'b0,1'b0,4'd5}, // R5 loss level
    '{1'b1,1'b0,1'b0,1'b0,12'd2047,1'b0,1'b0,4'd5}, // R5 one short
    '{1'b1,1'b0,1'b0,1'b0,12'd1,   1'b1,1'b1,4'd5}, // R5 relocked
    '{1'b0,1'b0,1'b0,1'b0,12'd1,   1'b0,1'b0,4'd2}, // R2 disable
    '{1'b1,1'b0,1'b0,1'b0,12'd2047,1'b0,1'b0,4'd2}, // R2 one short
    '{1'b1,1'b0,1'b0,1'b0,12'd1,   1'b1,1'b1,4'd2}, // R2 relocked
    '{1'b1,1'b0,1'b1,1'b1,12'd2,   1'b1,1'b0,4'd4}, // R4 drain on freq
    '{1'b1,1'b0,1'b0,1'b0,12'd1,   1'b0,1'b0,4'd6}, // R6 freq relock starts
    '{1'b1,1'b0,1'b0,1'b0,12'd2046,1'b0,1'b0,4'd6}, // R6 one short
    '{1'b1,1'b0,1'b0,1'b0,12'd1,   1'b1,1'b1,4'd6}  // R6 relocked
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic count_upd(input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (zq_upd) cnt++;
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    int c;
    // R1 reset state
    tick(3);
    chk("R1", "dll_locked", int'(dll_locked), 0);
    chk("R1", "ready", int'(ready), 0);
    chk("R1", "zq_upd", int'(zq_upd), 0);
    chk("R1", "zq_cal", int'(zq_cal), 0);
    rst = 1'b0;

    for (int i = 0; i < NSTEP; i++) begin
      dll_en   = STEPS[i].en;
      clk_lost = STEPS[i].lost;
      freq_chg = STEPS[i].fchg;
      ops_pend = STEPS[i].pend;
      tick(int'(STEPS[i].n));
      chk($sformatf("R%0d", STEPS[i].req), $sformatf("step %0d dll_locked", i),
          int'(dll_locked), int'(STEPS[i].exp_l));
      chk($sformatf("R%0d", STEPS[i].req), $sformatf("step %0d ready", i),
          int'(ready), int'(STEPS[i].exp_r));
    end

    // R1 reset again from a locked, calibrated state
    rst = 1'b1;
    tick(2);
    chk("R1", "dll_locked after reset", int'(dll_locked), 0);
    chk("R1", "zq_cal after reset", int'(zq_cal), 0);
    rst = 1'b0;

    // R8 reads do not count toward settling
    rd_cmd = 1'b1;
    tick(100);
    chk("R8", "zq_cal during reads", int'(zq_cal), 0);
    rd_cmd = 1'b0;
    tick(1023);
    chk("R8", "zq_cal one short", int'(zq_cal), 0);
    tick(1);
    chk("R8", "zq_cal settled", int'(zq_cal), 1);
    rd_cmd = 1'b1;
    tick(5);
    chk("R8", "zq_cal sticky", int'(zq_cal), 1);

    // R9 no strobe while outputs drive
    rd_cmd = 1'b0;
    out_active = 1'b1;
    count_upd(3 * INTV, c);
    chk("R9", "strobes while outputs active", c, 0);
    // R10 deferred update on first idle edge
    out_active = 1'b0;
    tick(1);
    chk("R10", "deferred strobe", int'(zq_upd), 1);
    // R10 cadence while idle
    count_upd(4 * INTV, c);
    chk("R10", "strobes in four intervals", c, 4);
    // R9 no strobe during reads
    rd_cmd = 1'b1;
    count_upd(3 * INTV, c);
    chk("R9", "strobes during reads", c, 0);
    rd_cmd = 1'b0;
    tick(1);
    chk("R10", "deferred strobe after reads", int'(zq_upd), 1);

    done = 1'b1;
    report();
  end
endmodule